// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing of a progressive display from a pixel clock. It has a sample counter that runs across each line and a line counter that runs down each field. A flag marks the active picture area. Event pulses mark the end of each field and a programmable corner of the bottom-field window. A sticky status register with a mask drives one interrupt line. All settings live in a small register file, which is written through a single-cycle write port and read back through a combinational read port.

The field height is programmed as a count of half-lines. In progressive operation software writes twice the number of lines. Window corners are packed words: the line number is 1-based and sits in the upper half, and the sample number is 0-based and sits in the lower half. The counters can be restarted in two ways: by writing the soft-restart register, or, in slave mode, by a rising edge on an external start input.

Top module: `video_timing_gen`

## Requirements
- R1: The sample counter runs 0, 1, ... up to the value in the line-length register (address 1) minus 1, then returns to 0 and advances the line counter.
- R2: The line counter is 1-based. It runs from 1 to half of the half-line count register (address 2) and then returns to 1.
- R3: `active` is high in exactly those cycles where the line lies between the line fields of the top start word (address 4) and top stop word (address 5) inclusive, and the sample lies between their sample fields inclusive. Each word holds the line in bits 31:16 and the sample in bits 15:0.
- R4: `top_evt` is high for exactly the one cycle in which the counters hold the last line and the last sample, which is the cycle before they wrap to line 1, sample 0.
- R5: `bot_evt` is high for exactly the cycles in which the counters equal the corner held in the bottom stop word (address 7, same packing as R3).
- R6: Status (read at address 8) sets bit 0 on a bottom event and bit 1 on a top event, one clock after the pulse. The bits stay set until a 1 is written to the same bit at address 9. If a set and a clear land on the same cycle, the set wins.
- R7: Writing 1s to address 10 sets mask bits and writing 1s to address 11 clears them. The mask reads back at address 10. `irq` is high exactly when some status bit and its mask bit are both 1.
- R8: Writing a value with bit 0 set to address 3 puts the counters at line 1, sample 0 on the next cycle.
- R9: The mode register (address 0, bit 0) selects master (0) or slave (1). In slave mode, the cycle after `ext_start` is first sampled high starts at line 1, sample 0. In master mode `ext_start` has no effect, and holding it high causes no further restarts.
- R10: After reset the counters are at line 1, sample 0. Status, mask, mode and all window words are 0. The line-length and half-line registers hold their parameter defaults. `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ext_start | input | 1 | External frame start, used in slave mode |
| active | output | 1 | Active-video window flag |
| top_evt | output | 1 | End-of-field pulse |
| bot_evt | output | 1 | Bottom-window corner pulse |
| irq | output | 1 | Masked interrupt request |

## Verification
`active`, `top_evt` and `bot_evt` are decoded directly from the counter registers, so each is valid in the same cycle as the counter position that produces it. A restart, whether from a write or from an external edge, takes effect at the clock edge that samples it. Status bits follow their event pulse by one edge. `irq` follows any status or mask change in the same cycle that change becomes visible. The bench keeps a cycle model of the counters, status and mask. At every falling edge it compares all four outputs with that model, applies the inputs for the next edge, and then advances the model by exactly one edge, so no check can slip by a cycle.

// File: rtl/vtg_pkg.sv
// Package: shared register address map, corner word layout and interrupt bit
// positions for the video timing generator.
package vtg_pkg;

    localparam int REG_AW  = 4;
    localparam int DATA_W  = 32;
    localparam int IRQ_W   = 2;
    localparam int IRQ_BOT = 0;
    localparam int IRQ_TOP = 1;

    typedef enum logic [REG_AW-1:0] {
        A_MODE    = 4'd0,
        A_CLKS    = 4'd1,
        A_HALVES  = 4'd2,
        A_SRST    = 4'd3,
        A_TSTART  = 4'd4,
        A_TSTOP   = 4'd5,
        A_BSTART  = 4'd6,
        A_BSTOP   = 4'd7,
        A_STAT    = 4'd8,
        A_STATCLR = 4'd9,
        A_MSET    = 4'd10,
        A_MCLR    = 4'd11
    } reg_addr_e;

    // Packed window corner: 1-based line above, 0-based sample below.
    typedef struct packed {
        logic [15:0] line;
        logic [15:0] samp;
    } corner_t;

endpackage

// File: rtl/vtg_regs.sv
// Module: vtg_regs
// Register file of the timing generator. It holds the mode, line length,
// field half-lines and window corners. It also decodes the strobes that
// have side effects: soft restart, status clear and mask set/clear.
// Assumes: single-cycle writes and CNT_W <= 16.
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEF_CLKS   = 858,
    parameter int DEF_HALVES = 1050
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 slave_mode,
    output logic [CNT_W-1:0]     clks,
    output logic [CNT_W:0]       halves,
    output corner_t              top_start,
    output corner_t              top_stop,
    output corner_t              bot_start,
    output corner_t              bot_stop,
    output logic                 soft_rst,
    output logic [IRQ_W-1:0]     stat_clr,
    output logic [IRQ_W-1:0]     mask_set,
    output logic [IRQ_W-1:0]     mask_clr
);

    // Purpose: decode the write strobes that act in the current cycle.
    always_comb begin
        soft_rst = wr_en && (wr_addr == A_SRST) && wr_data[0];
        stat_clr = (wr_en && wr_addr == A_STATCLR) ? wr_data[IRQ_W-1:0] : '0;
        mask_set = (wr_en && wr_addr == A_MSET)    ? wr_data[IRQ_W-1:0] : '0;
        mask_clr = (wr_en && wr_addr == A_MCLR)    ? wr_data[IRQ_W-1:0] : '0;
    end

    // Purpose: store the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_mode <= 1'b0;
            clks       <= CNT_W'(DEF_CLKS);
            halves     <= (CNT_W+1)'(DEF_HALVES);
            top_start  <= '0;
            top_stop   <= '0;
            bot_start  <= '0;
            bot_stop   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_MODE:   slave_mode <= wr_data[0];
                A_CLKS:   clks       <= wr_data[CNT_W-1:0];
                A_HALVES: halves     <= wr_data[CNT_W:0];
                A_TSTART: top_start  <= corner_t'(wr_data);
                A_TSTOP:  top_stop   <= corner_t'(wr_data);
                A_BSTART: bot_start  <= corner_t'(wr_data);
                A_BSTOP:  bot_stop   <= corner_t'(wr_data);
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/vtg_counters.sv
// Module: vtg_counters
// Sample and line counters. The sample counter wraps at the programmed
// line length. The line counter is 1-based and wraps after half the
// half-line count. A soft restart, or a slave-mode rising edge of the
// external start input, puts the counters at line 1, sample 0.
// Assumes: ext_start is synchronous to clk.
module vtg_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] clks,
    input  logic [CNT_W:0]   halves,
    input  logic             slave_mode,
    input  logic             ext_start,
    input  logic             soft_rst,
    output logic [CNT_W-1:0] h_cnt,
    output logic [CNT_W-1:0] v_cnt,
    output logic             frame_end
);

    logic             ext_q;
    logic             restart;
    logic             h_last;
    logic             v_last;
    logic [CNT_W-1:0] lines;

    // Purpose: end-of-line, end-of-field and restart conditions.
    always_comb begin
        lines     = halves[CNT_W:1];
        h_last    = ({1'b0, h_cnt} + 1'b1) >= {1'b0, clks};
        v_last    = v_cnt >= lines;
        frame_end = h_last && v_last;
        restart   = soft_rst || (slave_mode && ext_start && !ext_q);
    end

    // Purpose: remember the previous external start level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_start;
    end

    // Purpose: advance the raster position.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            h_cnt <= '0;
            v_cnt <= CNT_W'(1);
        end else if (h_last) begin
            h_cnt <= '0;
            v_cnt <= v_last ? CNT_W'(1) : v_cnt + 1'b1;
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vtg_window.sv
// Module: vtg_window
// Compares the raster position with the packed window corners. It drives
// the active flag from the top window and the bottom event from the
// bottom stop corner, and passes the field-end pulse through as the top event.
// Assumes: CNT_W <= 16, so a counter fits in a corner field.
module vtg_window
    import vtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic             frame_end,
    input  corner_t          top_start,
    input  corner_t          top_stop,
    input  corner_t          bot_stop,
    output logic             active,
    output logic             top_evt,
    output logic             bot_evt
);

    logic [15:0] h16;
    logic [15:0] v16;
    logic        in_lines;
    logic        in_samps;

    // Purpose: widen the counters and test the inclusive window bounds.
    always_comb begin
        h16      = 16'(h_cnt);
        v16      = 16'(v_cnt);
        in_lines = (v16 >= top_start.line) && (v16 <= top_stop.line);
        in_samps = (h16 >= top_start.samp) && (h16 <= top_stop.samp);
        active   = in_lines && in_samps;
        top_evt  = frame_end;
        bot_evt  = (v16 == bot_stop.line) && (h16 == bot_stop.samp);
    end

endmodule

// File: rtl/vtg_irq.sv
// Module: vtg_irq
// Sticky event status with write-1-to-clear, a mask with separate set and
// clear strobes, and the combined interrupt output. One slice is generated
// per event bit. Within a cycle a new event beats a clear, and a mask set
// beats a mask clear.
module vtg_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] stat_clr,
    input  logic [N-1:0] mask_set,
    input  logic [N-1:0] mask_clr,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Purpose: hold one status bit and one mask bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= 1'b0;
                mask[i]   <= 1'b0;
            end else begin
                status[i] <= evt[i] | (status[i] & ~stat_clr[i]);
                mask[i]   <= mask_set[i] | (mask[i] & ~mask_clr[i]);
            end
        end
    end

    // Purpose: raise the request while any enabled status bit is set.
    always_comb irq = |(status & mask);

endmodule

// File: rtl/video_timing_gen.sv
// Module: video_timing_gen (top)
// Progressive video timing generator: register file, raster counters,
// window decode and interrupt logic, with a combinational read mux.
// Assumes: progressive scan only. The bottom start word is stored and can
// be read back, but it does not affect the outputs.
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEF_CLKS   = 858,
    parameter int DEF_HALVES = 1050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ext_start,
    output logic              active,
    output logic              top_evt,
    output logic              bot_evt,
    output logic              irq
);

    logic             slave_mode;
    logic [CNT_W-1:0] clks;
    logic [CNT_W:0]   halves;
    corner_t          top_start, top_stop, bot_start, bot_stop;
    logic             soft_rst;
    logic [IRQ_W-1:0] stat_clr, mask_set, mask_clr;
    logic [IRQ_W-1:0] status, mask, evt;
    logic [CNT_W-1:0] h_cnt, v_cnt;
    logic             frame_end;

    vtg_regs #(.CNT_W(CNT_W), .DEF_CLKS(DEF_CLKS), .DEF_HALVES(DEF_HALVES)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slave_mode(slave_mode), .clks(clks),
        .halves(halves), .top_start(top_start), .top_stop(top_stop),
        .bot_start(bot_start), .bot_stop(bot_stop), .soft_rst(soft_rst),
        .stat_clr(stat_clr), .mask_set(mask_set), .mask_clr(mask_clr)
    );

    vtg_counters #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clks(clks), .halves(halves),
        .slave_mode(slave_mode), .ext_start(ext_start), .soft_rst(soft_rst),
        .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_end(frame_end)
    );

    vtg_window #(.CNT_W(CNT_W)) win_i (
        .h_cnt(h_cnt), .v_cnt(v_cnt), .frame_end(frame_end),
        .top_start(top_start), .top_stop(top_stop), .bot_stop(bot_stop),
        .active(active), .top_evt(top_evt), .bot_evt(bot_evt)
    );

    // Purpose: place each event pulse at its status bit position.
    always_comb begin
        evt          = '0;
        evt[IRQ_TOP] = top_evt;
        evt[IRQ_BOT] = bot_evt;
    end

    vtg_irq #(.N(IRQ_W)) irq_i (
        .clk(clk), .rst_n(rst_n), .evt(evt), .stat_clr(stat_clr),
        .mask_set(mask_set), .mask_clr(mask_clr), .status(status),
        .mask(mask), .irq(irq)
    );

    // Purpose: return the addressed register; strobe-only addresses read 0.
    always_comb begin
        case (rd_addr)
            A_MODE:   rd_data = {31'b0, slave_mode};
            A_CLKS:   rd_data = 32'(clks);
            A_HALVES: rd_data = 32'(halves);
            A_TSTART: rd_data = top_start;
            A_TSTOP:  rd_data = top_stop;
            A_BSTART: rd_data = bot_start;
            A_BSTOP:  rd_data = bot_stop;
            A_STAT:   rd_data = 32'(status);
            A_MSET:   rd_data = 32'(mask);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vtg_checker.sv
// Module: vtg_checker
// Temporal properties of the timing generator. The checker is bound into
// the top module and observes its internal counters and registers.
module vtg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [3:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [CNT_W-1:0] h_cnt,
    input logic [CNT_W-1:0] v_cnt,
    input logic [CNT_W-1:0] clks,
    input logic [1:0]       status,
    input logic [1:0]       mask,
    input logic             top_evt,
    input logic             bot_evt,
    input logic             irq
);

    // R1: at the last sample of a line the sample counter returns to 0
    a_r1_sample_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, h_cnt} + 1'b1) >= {1'b0, clks}) |=> (h_cnt == '0));

    // R2: the line counter never holds 0
    a_r2_line_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        v_cnt != '0);

    // R4: the field-end pulse is followed by the raster origin
    a_r4_top_then_origin: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt |=> (h_cnt == '0 && v_cnt == CNT_W'(1)));

    // R6: each event pulse latches its status bit
    a_r6_top_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        top_evt |=> status[1]);
    a_r6_bot_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        bot_evt |=> status[0]);

    // R7: no request can be raised while the mask is empty
    a_r7_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 2'b00) |-> !irq);

    // R8: a soft-restart write lands the counters at the origin
    a_r8_soft_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd3 && wr_data[0]) |=> (h_cnt == '0 && v_cnt == CNT_W'(1)));

endmodule

bind video_timing_gen vtg_checker #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .h_cnt(h_cnt), .v_cnt(v_cnt), .clks(clks),
    .status(status), .mask(mask), .top_evt(top_evt), .bot_evt(bot_evt),
    .irq(irq)
);

// File: tb/video_timing_gen_tb.sv
// Bench: a per-cycle arithmetic model of the raster, status and mask,
// compared with the outputs at every falling edge.
module video_timing_gen_tb_top;

    localparam int DEF_CLKS   = 858;
    localparam int DEF_HALVES = 1050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ext_start = 1'b0;
    logic        active, top_evt, bot_evt, irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    int          mh, mv, mclks, mhalves;
    logic [31:0] mts, mtp, mbs, mbp;
    logic        mmode, mextq;
    logic [1:0]  mstat, mmask;
    logic        ext_lvl = 1'b0;

    video_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_start(ext_start), .active(active), .top_evt(top_evt),
        .bot_evt(bot_evt), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    // Compare outputs now, drive inputs, advance the model one edge.
    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d);
        int  lines;
        logic hl, vl, e_top, e_bot, e_act, e_irq, rise, srst;
        logic [1:0] clr, mset, mclr;
        lines = mhalves / 2;
        hl    = (mh + 1) >= mclks;
        vl    = mv >= lines;
        e_top = hl && vl;
        e_bot = (mv == int'(mbp[31:16])) && (mh == int'(mbp[15:0]));
        e_act = (mv >= int'(mts[31:16])) && (mv <= int'(mtp[31:16])) &&
                (mh >= int'(mts[15:0]))  && (mh <= int'(mtp[15:0]));
        e_irq = |(mstat & mmask);
        chk("R3 active", 32'(active), 32'(e_act));
        chk("R4 top_evt", 32'(top_evt), 32'(e_top));
        chk("R5 bot_evt", 32'(bot_evt), 32'(e_bot));
        chk("R7 irq", 32'(irq), 32'(e_irq));
        wr_en = we; wr_addr = a; wr_data = d; ext_start = ext_lvl;
        rise  = mmode && ext_lvl && !mextq;
        mextq = ext_lvl;
        srst  = we && a == 4'd3 && d[0];
        if (srst || rise) begin mh = 0; mv = 1; end
        else if (hl) begin mh = 0; mv = vl ? 1 : mv + 1; end
        else mh = mh + 1;
        clr   = (we && a == 4'd9)  ? d[1:0] : 2'b00;
        mset  = (we && a == 4'd10) ? d[1:0] : 2'b00;
        mclr  = (we && a == 4'd11) ? d[1:0] : 2'b00;
        mstat = (mstat & ~clr) | {e_top, e_bot};
        mmask = (mmask & ~mclr) | mset;
        if (we) begin
            case (a)
                4'd0: mmode   = d[0];
                4'd1: mclks   = int'(d[15:0]);
                4'd2: mhalves = int'(d[16:0]);
                4'd4: mts     = d;
                4'd5: mtp     = d;
                4'd6: mbs     = d;
                4'd7: mbp     = d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 32'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    initial begin
        mh = 0; mv = 1; mclks = DEF_CLKS; mhalves = DEF_HALVES;
        mts = '0; mtp = '0; mbs = '0; mbp = '0;
        mmode = 1'b0; mextq = 1'b0; mstat = '0; mmask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        rdchk(4'd1, 32'(DEF_CLKS), "R10 line length default");
        rdchk(4'd2, 32'(DEF_HALVES), "R10 half-line default");
        rdchk(4'd8, 32'd0, "R10 status");
        rdchk(4'd10, 32'd0, "R10 mask");
        rdchk(4'd0, 32'd0, "R10 mode");
        rdchk(4'd4, 32'd0, "R10 window");
        chk("R10 irq", 32'(irq), 32'd0);
        run(3);
        // small raster: 10 samples, 6 lines
        wr(4'd1, 32'd10);
        wr(4'd2, 32'd12);
        wr(4'd4, {16'd3, 16'd2});
        wr(4'd5, {16'd5, 16'd7});
        wr(4'd6, {16'd3, 16'd2});
        wr(4'd7, {16'd6, 16'd4});
        rdchk(4'd6, {16'd3, 16'd2}, "R3 bottom start readback");
        wr(4'd9, 32'd3);
        wr(4'd3, 32'd1);                // R8 soft restart
        run(130);                       // R1 R2 R3 R4 R5 sweep
        rdchk(4'd8, 32'd3, "R6 both status bits");
        wr(4'd10, 32'd2);               // R7 mask top
        run(65);
        wr(4'd9, 32'd3);                // R6 clear
        wr(4'd11, 32'd2);
        wr(4'd10, 32'd1);
        rdchk(4'd10, 32'd1, "R7 mask readback");
        run(70);
        wr(4'd3, 32'd0);                // R8 bit 0 clear: no restart
        run(17);
        wr(4'd3, 32'd1);
        run(23);
        // R9 slave mode
        wr(4'd0, 32'd1);
        run(11);
        ext_lvl = 1'b1;
        run(7);                         // held high: only one restart
        ext_lvl = 1'b0;
        run(70);
        // R9 master mode ignores ext_start
        wr(4'd0, 32'd0);
        run(13);
        ext_lvl = 1'b1;
        run(3);
        ext_lvl = 1'b0;
        run(60);
        // reprogram: 7 samples, 4 lines, full-width window
        wr(4'd1, 32'd7);
        wr(4'd2, 32'd8);
        wr(4'd4, {16'd2, 16'd0});
        wr(4'd5, {16'd4, 16'd6});
        wr(4'd7, {16'd1, 16'd0});
        wr(4'd3, 32'd1);
        run(90);
        wr(4'd9, 32'd3);
        rdchk(4'd8, 32'(mstat), "R6 status after clear");
        run(5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule